// File: doc/BRIEF.md
# Packed Double to Signed Integer Converter

This block turns a pair of IEEE-754 double-precision numbers, carried in the two 64-bit halves of a 128-bit input word, into a pair of signed 32-bit integers. Each lane is rounded by the mode on a 2-bit rounding input. The lane results go into the low 64 bits of the output word, and the upper 64 bits always read as zero. A lane whose input is a NaN or an infinity, or whose rounded value does not fit the integer range, is invalid. Such a lane yields the integer indefinite pattern 8000_0000h. A lane whose result lost fraction bits reports precision loss.

Each of the two exception kinds has its own mask input. If an exception occurs while its mask is clear, the block raises a trap request and does not write a result: the data word is all zeros and the flags still show what occurred. Operands enter through a valid/ready handshake. They are converted in one step and held in a single output register until the consumer takes them.

Top module: `pd2i_conv`

## Requirements
- R1: Lane 0 reads input bits 63:0 and writes output bits 31:0. Lane 1 reads input bits 127:64 and writes output bits 63:32. Each result is the two's-complement integer of the rounded input.
- R2: Output bits 127:64 are zero in every delivered word.
- R3: The rounding input selects the mode. 2'b00 is round to nearest with ties to even. 2'b01 rounds toward minus infinity. 2'b10 rounds toward plus infinity. 2'b11 rounds toward zero.
- R4: A NaN (quiet or signalling), plus or minus infinity, or a rounded value outside -2^31..2^31-1 sets out_inv. With mask_inv high, that lane yields 8000_0000h.
- R5: The range test is applied after rounding. For example, 2147483647.4 to nearest gives 7FFF_FFFFh. 2147483647.5 to nearest is invalid. -2147483648.5 toward zero gives 8000_0000h and is valid, but toward minus infinity it is invalid.
- R6: out_prec is set when a valid lane's rounded result differs from its input. A lane that is invalid never contributes to out_prec. The two flags are ORed over both lanes.
- R7: A denormal input gives 0 under nearest and toward-zero rounding. It gives -1 (negative input, toward minus infinity) or +1 (positive input, toward plus infinity) under directed rounding. It always sets out_prec.
- R8: If out_inv is set while mask_inv is low, or out_prec is set while mask_prec is low, out_trap is high and out_data is all zeros. The flags are still reported.
- R9: in_ready equals !out_valid || out_ready. An accepted input appears on the outputs on the next clock edge. A word that is not taken stays on the outputs unchanged.
- R10: After reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand word offered |
| in_ready | output | 1 | Block can take an operand word |
| in_data | input | 128 | Two doubles, lane 0 in the low half |
| rnd_mode | input | 2 | Rounding mode (see R3) |
| mask_inv | input | 1 | High masks the invalid exception |
| mask_prec | input | 1 | High masks the precision exception |
| out_valid | output | 1 | Result word present |
| out_ready | input | 1 | Consumer takes the result word |
| out_data | output | 128 | Two int32 results in bits 63:0, upper half zero |
| out_inv | output | 1 | Invalid occurred in some lane |
| out_prec | output | 1 | Precision loss occurred in some valid lane |
| out_trap | output | 1 | Unmasked exception; no result written |

## Verification
Invalid reporting and precision reporting can both occur in the same conversion, because each lane produces its own flags in the same cycle. The bench provokes this with operand pairs that put a NaN or an out-of-range value in one lane and an inexact value in the other. It also puts an invalid lane next to an exact lane and varies the two masks independently. The reference model decides, lane by lane, which flag each lane may raise. The comparison then checks that the precision flag and the trap come only from the inexact valid lane, and that an invalid lane alone never causes a precision trap.

// File: rtl/pd2i_pkg.sv
package pd2i_pkg;
   localparam int DBL_W  = 64;
   localparam int EXP_W  = 11;
   localparam int FRAC_W = 52;
   localparam int MANT_W = FRAC_W + 1;
   localparam int BIAS   = 1023;

   typedef enum logic [1:0] {
      RND_NEAR = 2'b00,
      RND_DOWN = 2'b01,
      RND_UP   = 2'b10,
      RND_ZERO = 2'b11
   } rnd_e;
endpackage

// File: rtl/pd2i_rnd_inc.sv
module pd2i_rnd_inc
   import pd2i_pkg::*;
(
   input  rnd_e rnd,
   input  logic sgn,
   input  logic lsb,
   input  logic guard,
   input  logic sticky,
   output logic inc
);
   always_comb begin
      unique case (rnd)
         RND_NEAR: inc = guard & (sticky | lsb);
         RND_DOWN: inc = sgn & (guard | sticky);
         RND_UP:   inc = ~sgn & (guard | sticky);
         default:  inc = 1'b0;
      endcase
   end
endmodule

// File: rtl/pd2i_lane.sv
module pd2i_lane
   import pd2i_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  logic [DBL_W-1:0] dbl,
   input  rnd_e             rnd,
   output logic [INT_W-1:0] res,
   output logic             inv,
   output logic             prec
);
   localparam int FR_W  = MANT_W + 1;
   localparam int EXT_W = MANT_W + FR_W;
   localparam int SH_W  = 12;
   localparam logic [SH_W-1:0] SH_ZERO  = SH_W'(BIAS + FRAC_W);
   localparam logic [SH_W-1:0] BIG_EXP  = SH_W'(BIAS + INT_W);
   localparam logic [SH_W-1:0] TINY_SH  = SH_W'(MANT_W + 1);
   localparam logic [MANT_W:0] LIM      = (MANT_W+1)'(1) << (INT_W - 1);
   localparam logic [INT_W-1:0] INDEF   = {1'b1, {(INT_W-1){1'b0}}};

   logic              sgn;
   logic [EXP_W-1:0]  ex;
   logic [MANT_W-1:0] mant;
   logic [SH_W-1:0]   sh;
   logic              special, big, tiny, over;
   logic [EXT_W-1:0]  ext;
   logic [MANT_W-1:0] ipart;
   logic              guard, sticky, inc;
   logic [MANT_W:0]   mag;

   assign sgn     = dbl[DBL_W-1];
   assign ex      = dbl[DBL_W-2 -: EXP_W];
   assign mant    = {|ex, dbl[FRAC_W-1:0]};
   assign special = &ex;
   assign big     = {1'b0, ex} >= BIG_EXP;
   assign sh      = SH_ZERO - {1'b0, (ex == '0) ? EXP_W'(1) : ex};
   assign tiny    = sh > TINY_SH;
   assign ext     = {mant, {FR_W{1'b0}}} >> sh;

   always_comb begin
      if (tiny) begin
         ipart  = '0;
         guard  = 1'b0;
         sticky = |mant;
      end else begin
         ipart  = ext[EXT_W-1 -: MANT_W];
         guard  = ext[FR_W-1];
         sticky = |ext[FR_W-2:0];
      end
   end

   pd2i_rnd_inc u_inc (
      .rnd    (rnd),
      .sgn    (sgn),
      .lsb    (ipart[0]),
      .guard  (guard),
      .sticky (sticky),
      .inc    (inc)
   );

   assign mag  = {1'b0, ipart} + {{MANT_W{1'b0}}, inc};
   assign over = sgn ? (mag > LIM) : (mag >= LIM);
   assign inv  = special | big | over;
   assign prec = ~inv & (guard | sticky);
   assign res  = inv ? INDEF : (sgn ? -mag[INT_W-1:0] : mag[INT_W-1:0]);
endmodule

// File: rtl/pd2i_conv.sv
module pd2i_conv
   import pd2i_pkg::*;
#(
   parameter int LANES = 2,
   parameter int INT_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   output logic                   in_ready,
   input  logic [LANES*DBL_W-1:0] in_data,
   input  logic [1:0]             rnd_mode,
   input  logic                   mask_inv,
   input  logic                   mask_prec,
   output logic                   out_valid,
   input  logic                   out_ready,
   output logic [LANES*DBL_W-1:0] out_data,
   output logic                   out_inv,
   output logic                   out_prec,
   output logic                   out_trap
);
   localparam int DATA_W = LANES * DBL_W;
   localparam int RES_W  = LANES * INT_W;

   if (INT_W < 2 || INT_W > FRAC_W) begin : g_bad_int_w
      $error("pd2i_conv: INT_W out of supported range");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("pd2i_conv: LANES must be at least 1");
   end

   logic [RES_W-1:0]  res_vec;
   logic [LANES-1:0]  inv_v, prec_v;
   logic [DATA_W-1:0] packed_res;
   logic              any_inv, any_prec, trap, accept;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      pd2i_lane #(.INT_W(INT_W)) u_lane (
         .dbl  (in_data[g*DBL_W +: DBL_W]),
         .rnd  (rnd_e'(rnd_mode)),
         .res  (res_vec[g*INT_W +: INT_W]),
         .inv  (inv_v[g]),
         .prec (prec_v[g])
      );
   end

   if (DATA_W > RES_W) begin : g_zero_fill
      assign packed_res = {{(DATA_W-RES_W){1'b0}}, res_vec};
   end else begin : g_no_fill
      assign packed_res = res_vec;
   end

   assign any_inv  = |inv_v;
   assign any_prec = |prec_v;
   assign trap     = (any_inv & ~mask_inv) | (any_prec & ~mask_prec);
   assign in_ready = ~out_valid | out_ready;
   assign accept   = in_valid & in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_inv   <= 1'b0;
         out_prec  <= 1'b0;
         out_trap  <= 1'b0;
      end else if (accept) begin
         out_valid <= 1'b1;
         out_data  <= trap ? '0 : packed_res;
         out_inv   <= any_inv;
         out_prec  <= any_prec;
         out_trap  <= trap;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end
endmodule

// File: rtl/pd2i_conv_chk.sv
module pd2i_conv_chk #(
   parameter int LANES = 2,
   parameter int INT_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_ready,
   input logic                out_valid,
   input logic                out_ready,
   input logic [LANES*64-1:0] out_data,
   input logic                out_inv,
   input logic                out_prec,
   input logic                out_trap
);
   localparam int RES_W = LANES * INT_W;
   localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

   logic any_indef;
   always_comb begin
      any_indef = 1'b0;
      for (int i = 0; i < LANES; i++)
         if (out_data[i*INT_W +: INT_W] == INDEF) any_indef = 1'b1;
   end

   // R9
   accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);

   // R9
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_inv)
                                  && $stable(out_prec) && $stable(out_trap));

   // R2
   upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_data[LANES*64-1:RES_W] == '0);

   // R8
   trap_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_trap |-> out_data == '0);

   // R8
   trap_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_trap |-> out_inv || out_prec);

   // R4
   indef_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_inv && !out_trap |-> any_indef);
endmodule

bind pd2i_conv pd2i_conv_chk #(.LANES(LANES), .INT_W(INT_W)) u_pd2i_conv_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_inv   (out_inv),
   .out_prec  (out_prec),
   .out_trap  (out_trap)
);

// File: tb/pd2i_conv_bench.sv
`timescale 1ns/1ps
module pd2i_conv_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic         in_ready;
   logic [127:0] in_data = '0;
   logic [1:0]   rnd_mode = 2'b00;
   logic         mask_inv = 1'b1;
   logic         mask_prec = 1'b1;
   logic         out_valid;
   logic         out_ready = 1'b1;
   logic [127:0] out_data;
   logic         out_inv, out_prec, out_trap;

   always #4 clk = ~clk;

   pd2i_conv u_pd2i_conv (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .rnd_mode(rnd_mode), .mask_inv(mask_inv),
      .mask_prec(mask_prec), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .out_inv(out_inv), .out_prec(out_prec), .out_trap(out_trap)
   );

   typedef struct {
      logic [127:0] data;
      logic         inv;
      logic         prec;
      logic         trap;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   started = 1'b0;
   bit   bp_en = 1'b0;
   bit   done = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: {inv, prec, int32}
   function automatic logic [33:0] ref_lane(input logic [63:0] d, input logic [1:0] rm);
      real x, t, f, r;
      if (d[62:52] == 11'h7FF) return {1'b1, 1'b0, 32'h8000_0000};
      x = $bitstoreal(d);
      t = $floor(x);
      f = x - t;
      case (rm)
         2'b00: begin
            if (f > 0.5) r = t + 1.0;
            else if (f < 0.5) r = t;
            else r = ($floor(t / 2.0) * 2.0 == t) ? t : t + 1.0;
         end
         2'b01: r = t;
         2'b10: r = (f > 0.0) ? t + 1.0 : t;
         default: r = (x < 0.0 && f > 0.0) ? t + 1.0 : t;
      endcase
      if (r > 2147483647.0 || r < -2147483648.0) return {1'b1, 1'b0, 32'h8000_0000};
      return {1'b0, (f != 0.0), 32'($rtoi(r))};
   endfunction

   function automatic exp_t model(input logic [127:0] d, input logic [1:0] rm, input bit mi, input bit mp);
      exp_t e;
      logic [33:0] l0, l1;
      l0 = ref_lane(d[63:0], rm);
      l1 = ref_lane(d[127:64], rm);
      e.inv  = l0[33] | l1[33];
      e.prec = l0[32] | l1[32];
      e.trap = (e.inv & !mi) | (e.prec & !mp);
      e.data = e.trap ? 128'h0 : {64'h0, l1[31:0], l0[31:0]};
      return e;
   endfunction

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && started && !done) begin
         exp_t e;
         chk(in_ready == (q.size() == 0 || out_ready), "R9 in_ready", 128'(in_ready), 128'(q.size() == 0 || out_ready));
         chk(out_valid == (q.size() != 0), "R9 out_valid", 128'(out_valid), 128'(q.size() != 0));
         if (out_valid && q.size() != 0) begin
            e = q[0];
            chk(out_data[63:0] == e.data[63:0], "R1 lane results", out_data[63:0], e.data[63:0]);
            chk(out_data[127:64] == 64'h0, "R2 upper half", out_data[127:64], 128'h0);
            chk(out_inv == e.inv, "R4 invalid flag", 128'(out_inv), 128'(e.inv));
            chk(out_prec == e.prec, "R6 precision flag", 128'(out_prec), 128'(e.prec));
            chk(out_trap == e.trap, "R8 trap", 128'(out_trap), 128'(e.trap));
            if (out_ready) void'(q.pop_front());
         end
         if (in_valid && in_ready) q.push_back(model(in_data, rnd_mode, mask_inv, mask_prec));
      end
   end

   always @(posedge clk) begin
      #1;
      out_ready = bp_en ? 1'($urandom % 2) : 1'b1;
   end

   task automatic send(input logic [63:0] a, input logic [63:0] b, input logic [1:0] rm,
                       input bit mi, input bit mp);
      in_data = {b, a};
      rnd_mode = rm;
      mask_inv = mi;
      mask_prec = mp;
      in_valid = 1'b1;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   function automatic logic [63:0] rb(input real v);
      return $realtobits(v);
   endfunction

   task automatic finish_run();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      #(8 * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      // R10: reset state
      chk(out_valid == 1'b0, "R10 out_valid after reset", 128'(out_valid), 128'h0);
      chk(in_ready == 1'b1, "R10 in_ready after reset", 128'(in_ready), 128'h1);
      @(posedge clk);
      #1;
      started = 1'b1;

      // R1: exact values in both lanes
      send(rb(3.0), rb(-7.0), 2'b00, 1, 1);
      send(rb(123456789.0), rb(-2147483648.0), 2'b00, 1, 1);
      // R3: each rounding mode on ties and fractions
      for (int m = 0; m < 4; m++) begin
         send(rb(2.5), rb(-2.5), 2'(m), 1, 1);
         send(rb(1.5), rb(-1.5), 2'(m), 1, 1);
         send(rb(1.7), rb(-1.7), 2'(m), 1, 1);
         send(rb(0.5), rb(-0.25), 2'(m), 1, 1);
      end
      // R4: NaNs, infinities and out-of-range magnitudes
      send(64'h7FF8_0000_0000_0000, 64'h7FF0_0000_0000_0001, 2'b00, 1, 1);
      send(64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000, 2'b11, 1, 1);
      send(rb(3.0e9), rb(-3.0e9), 2'b01, 1, 1);
      send(rb(1.0e300), rb(2147483648.0), 2'b11, 1, 1);
      // R5: range test after rounding
      send(rb(2147483647.4), rb(2147483647.5), 2'b00, 1, 1);
      send(rb(-2147483648.5), rb(-2147483648.5), 2'b11, 1, 1);
      send(rb(-2147483648.5), rb(2147483647.5), 2'b01, 1, 1);
      send(rb(2147483647.5), rb(-2147483648.5), 2'b00, 1, 1);
      // R7: denormals in every mode
      for (int m = 0; m < 4; m++)
         send(64'h0000_0000_0000_0001, 64'h800F_FFFF_FFFF_FFFF, 2'(m), 1, 1);
      // R8: unmasked exceptions
      send(rb(1.25), rb(4.0), 2'b00, 1, 0);
      send(64'h7FF8_0000_0000_0000, rb(4.0), 2'b00, 0, 1);
      send(rb(8.0), rb(-9.0), 2'b00, 0, 0);
      // R6: invalid and inexact lanes in the same word
      send(64'h7FF8_0000_0000_0000, rb(1.25), 2'b00, 1, 0);
      send(64'h7FF8_0000_0000_0000, rb(6.0), 2'b00, 1, 0);
      send(rb(3.0e10), rb(2.75), 2'b10, 0, 1);
      send(rb(2147483647.5), rb(-1.0), 2'b00, 1, 0);

      // random values near the integer range, no back-pressure, then with it (R9)
      for (int pass = 0; pass < 2; pass++) begin
         bp_en = (pass == 1);
         for (int i = 0; i < 300; i++) begin
            logic [63:0] a, b;
            a = {1'($urandom), 11'(990 + $urandom % 70), 20'($urandom), 32'($urandom)};
            b = {1'($urandom), 11'(990 + $urandom % 70), 20'($urandom), 32'($urandom)};
            if ($urandom % 8 == 0) b[62:52] = ($urandom % 2) ? 11'h7FF : 11'h000;
            send(a, b, 2'($urandom), 1'($urandom), 1'($urandom));
         end
      end
      bp_en = 1'b0;
      repeat (10) @(posedge clk);
      #1;
      chk(q.size() == 0, "R9 drained", 128'(q.size()), 128'h0);
      finish_run();
   end
endmodule